// File: doc/BRIEF.md
# Colour Lookup Table Host Port

This block holds a 256-entry colour lookup table, each entry a 24-bit RGB value, and gives a host byte-wide register access to it. To load the table, the host writes a start address and then streams bytes through a single data register in the order red, green, blue. After each complete triple the address moves to the next entry, so a run of triples fills consecutive entries. Reading works the same way from a separate read start address. The write-address register also acts as the index for a small set of indirect registers, which are reached through an indirect data register.

A pixel port runs alongside the host port. It takes an 8-bit pixel index, ANDs it with a host-programmed read mask, and returns the addressed entry one cycle later. The returned entry depends on a misc control register. In 6-bit DAC mode each channel is narrowed to its upper six bits, shifted down. When the DAC is powered off the returned value is zero.

Top module: `clut_host_port`

## Requirements
- R1: After reset, the write address, read address, pixel mask and misc control registers all read as 0x00, and `host_rvalid` and `pix_out_valid` are low.
- R2: Host writes to select 0x1 are taken as red, green, then blue. The 24-bit entry at the write address is stored only when blue arrives, and the write address then increments. It can be read back at select 0x0.
- R3: A host read of any select returns its byte on `host_rdata` with `host_rvalid` high exactly one cycle after `host_rd`. Reads of select 0x1 return red, green, then blue of the entry at the read address (select 0x3), and the read address increments after blue.
- R4: Writing select 0x0 or select 0x3 restarts that direction's sequence at red. A partial write triple that is abandoned this way leaves the table unchanged.
- R5: The red read captures the whole entry. The green and blue reads that follow return that captured entry, even if the host rewrites the entry in between.
- R6: A pulse on `pix_valid` gives `pix_out_valid` high one cycle later. `pix_rgb` then carries the entry at `pix_index AND mask`, where the mask is written at select 0x2. Red is in bits 23:16, green in 15:8 and blue in 7:0. `pix_rgb` is zero while `pix_out_valid` is low.
- R7: Select 0xA reads and writes the indirect register chosen by the value last written to select 0x0. Index 0x1E is misc control. Any other index reads 0x00 and ignores writes.
- R8: When misc bit 1 is clear (6-bit mode), each channel of `pix_rgb` equals the stored channel shifted right by two. When the bit is set, channels are returned unchanged.
- R9: When misc bit 0 is set (DAC off), `pix_rgb` is zero even though `pix_out_valid` still pulses.
- R10: The read and write addresses wrap from 0xFF to 0x00 after a triple.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 4 | Host register select |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| host_rvalid | output | 1 | Read byte valid, one cycle after host_rd |
| pix_valid | input | 1 | Pixel lookup request |
| pix_index | input | 8 | Pixel index |
| pix_out_valid | output | 1 | Lookup result valid |
| pix_rgb | output | 24 | Looked-up colour, red in the top byte |

## Verification
Each result is due exactly one register stage after its stimulus. A host read byte appears on the cycle after `host_rd`, and a pixel colour appears on the cycle after `pix_valid`. Table writes and register writes take effect at the edge that samples them, so a read issued in the following cycle already sees them. The driver tasks push each expected value into a queue as they raise the strobe. A monitor samples at the falling edge, and whenever a valid flag is high it pops the oldest expected value and compares it. A result that arrives early, late or unrequested therefore lands against the wrong expectation or an empty queue.

// File: rtl/clut_pkg.sv
package clut_pkg;
    localparam int unsigned CH_W     = 8;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned SEL_W    = 4;

    localparam logic [SEL_W-1:0] SEL_WADDR = 4'h0;
    localparam logic [SEL_W-1:0] SEL_DATA  = 4'h1;
    localparam logic [SEL_W-1:0] SEL_MASK  = 4'h2;
    localparam logic [SEL_W-1:0] SEL_RADDR = 4'h3;
    localparam logic [SEL_W-1:0] SEL_IDATA = 4'hA;

    localparam logic [CH_W-1:0] IDX_MISC = 8'h1E;
    localparam int unsigned MISC_PWR_OFF = 0;
    localparam int unsigned MISC_WIDE    = 1;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    typedef enum logic [1:0] {PH_RED = 2'd0, PH_GRN = 2'd1, PH_BLU = 2'd2} phase_e;
endpackage

// File: rtl/clut_ram.sv
module clut_ram
    import clut_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  rgb_t          wdata,
    input  logic [AW-1:0] host_raddr,
    output rgb_t          host_rdata,
    input  logic [AW-1:0] pix_raddr,
    output rgb_t          pix_rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    rgb_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign host_rdata = mem[host_raddr];
    assign pix_rdata  = mem[pix_raddr];
endmodule

// File: rtl/clut_host_regs.sv
module clut_host_regs
    import clut_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [CH_W-1:0]   host_wdata,
    output logic [CH_W-1:0]   host_rdata,
    output logic              host_rvalid,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_waddr,
    output rgb_t              ram_wdata,
    output logic [ADDR_W-1:0] ram_raddr,
    input  rgb_t              ram_rdata,
    output logic [CH_W-1:0]   mask,
    output logic [CH_W-1:0]   misc,
    output phase_e            wr_phase
);
    typedef struct packed {
        logic [ADDR_W-1:0] waddr;
        logic [ADDR_W-1:0] raddr;
        phase_e            wph;
        phase_e            rph;
        logic [CH_W-1:0]   stg_r;
        logic [CH_W-1:0]   stg_g;
        rgb_t              rlatch;
        logic [CH_W-1:0]   mask;
        logic [CH_W-1:0]   misc;
        logic [CH_W-1:0]   rdata;
        logic              rvalid;
    } hst_t;

    hst_t st_d, st_q;
    logic we_d;
    rgb_t wdata_d;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = host_rd;
        we_d        = 1'b0;
        wdata_d     = '{r: st_q.stg_r, g: st_q.stg_g, b: host_wdata};

        if (host_wr) begin
            unique case (host_sel)
                SEL_WADDR: begin
                    st_d.waddr = host_wdata;
                    st_d.wph   = PH_RED;
                end
                SEL_RADDR: begin
                    st_d.raddr = host_wdata;
                    st_d.rph   = PH_RED;
                end
                SEL_MASK:  st_d.mask = host_wdata;
                SEL_IDATA: begin
                    if (st_q.waddr == IDX_MISC) st_d.misc = host_wdata;
                end
                SEL_DATA: begin
                    unique case (st_q.wph)
                        PH_RED: begin
                            st_d.stg_r = host_wdata;
                            st_d.wph   = PH_GRN;
                        end
                        PH_GRN: begin
                            st_d.stg_g = host_wdata;
                            st_d.wph   = PH_BLU;
                        end
                        default: begin
                            we_d       = 1'b1;
                            st_d.waddr = st_q.waddr + 1'b1;
                            st_d.wph   = PH_RED;
                        end
                    endcase
                end
                default: ;
            endcase
        end

        if (host_rd) begin
            st_d.rdata = '0;
            unique case (host_sel)
                SEL_WADDR: st_d.rdata = st_q.waddr;
                SEL_RADDR: st_d.rdata = st_q.raddr;
                SEL_MASK:  st_d.rdata = st_q.mask;
                SEL_IDATA: begin
                    if (st_q.waddr == IDX_MISC) st_d.rdata = st_q.misc;
                end
                SEL_DATA: begin
                    unique case (st_q.rph)
                        PH_RED: begin
                            st_d.rlatch = ram_rdata;
                            st_d.rdata  = ram_rdata.r;
                            st_d.rph    = PH_GRN;
                        end
                        PH_GRN: begin
                            st_d.rdata = st_q.rlatch.g;
                            st_d.rph   = PH_BLU;
                        end
                        default: begin
                            st_d.rdata = st_q.rlatch.b;
                            st_d.raddr = st_q.raddr + 1'b1;
                            st_d.rph   = PH_RED;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_rdata  = st_q.rdata;
    assign host_rvalid = st_q.rvalid;
    assign ram_we      = we_d;
    assign ram_waddr   = st_q.waddr;
    assign ram_wdata   = wdata_d;
    assign ram_raddr   = st_q.raddr;
    assign mask        = st_q.mask;
    assign misc        = st_q.misc;
    assign wr_phase    = st_q.wph;
endmodule

// File: rtl/clut_pixel_path.sv
module clut_pixel_path
    import clut_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic [CH_W-1:0]   pix_index,
    input  logic [CH_W-1:0]   mask,
    input  logic [CH_W-1:0]   misc,
    output logic [ADDR_W-1:0] lookup_addr,
    input  rgb_t              lookup_data,
    output logic              out_valid,
    output rgb_t              out_rgb
);
    localparam int unsigned NARROW = 2;

    typedef struct packed {
        logic valid;
        rgb_t rgb;
    } pix_t;

    pix_t px_d, px_q;

    assign lookup_addr = pix_index & mask;

    always_comb begin
        px_d.valid = pix_valid;
        px_d.rgb   = '0;
        if (pix_valid && !misc[MISC_PWR_OFF]) begin
            if (misc[MISC_WIDE]) begin
                px_d.rgb = lookup_data;
            end else begin
                px_d.rgb.r = lookup_data.r >> NARROW;
                px_d.rgb.g = lookup_data.g >> NARROW;
                px_d.rgb.b = lookup_data.b >> NARROW;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) px_q <= '0;
        else        px_q <= px_d;
    end

    assign out_valid = px_q.valid;
    assign out_rgb   = px_q.rgb;
endmodule

// File: rtl/clut_host_port.sv
module clut_host_port
    import clut_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  host_sel,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        host_rvalid,
    input  logic        pix_valid,
    input  logic [7:0]  pix_index,
    output logic        pix_out_valid,
    output logic [23:0] pix_rgb
);
    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    rgb_t              ram_wdata;
    logic [ADDR_W-1:0] ram_raddr;
    rgb_t              ram_rdata;
    logic [ADDR_W-1:0] pix_addr;
    rgb_t              pix_entry;
    logic [CH_W-1:0]   mask_w;
    logic [CH_W-1:0]   misc_w;
    phase_e            wph_w;
    rgb_t              pix_out_w;

    clut_host_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .host_rvalid(host_rvalid),
        .ram_we     (ram_we),
        .ram_waddr  (ram_waddr),
        .ram_wdata  (ram_wdata),
        .ram_raddr  (ram_raddr),
        .ram_rdata  (ram_rdata),
        .mask       (mask_w),
        .misc       (misc_w),
        .wr_phase   (wph_w)
    );

    clut_ram #(.AW(ADDR_W)) u_ram (
        .clk       (clk),
        .we        (ram_we),
        .waddr     (ram_waddr),
        .wdata     (ram_wdata),
        .host_raddr(ram_raddr),
        .host_rdata(ram_rdata),
        .pix_raddr (pix_addr),
        .pix_rdata (pix_entry)
    );

    clut_pixel_path u_pix (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_valid  (pix_valid),
        .pix_index  (pix_index),
        .mask       (mask_w),
        .misc       (misc_w),
        .lookup_addr(pix_addr),
        .lookup_data(pix_entry),
        .out_valid  (pix_out_valid),
        .out_rgb    (pix_out_w)
    );

    assign pix_rgb = pix_out_w;
endmodule

// File: rtl/clut_host_port_chk.sv
module clut_host_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  host_sel,
    input logic        host_wr,
    input logic        host_rd,
    input logic        host_rvalid,
    input logic        pix_valid,
    input logic        pix_out_valid,
    input logic [23:0] pix_rgb,
    input logic [7:0]  misc_w,
    input logic [7:0]  waddr_w,
    input logic [1:0]  wph_w
);
    assert_rvalid_after_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> host_rvalid);
    assert_no_spurious_rvalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> !host_rvalid);
    assert_pix_valid_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> pix_out_valid);
    assert_pix_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_out_valid |-> pix_rgb == 24'h0);
    assert_dac_off_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && misc_w[0]) |=> pix_rgb == 24'h0);
    assert_six_bit_narrow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !misc_w[1]) |=>
            (pix_rgb[23:22] == 2'b00 && pix_rgb[15:14] == 2'b00 && pix_rgb[7:6] == 2'b00));
    assert_waddr_step_on_blue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 4'h1 && wph_w == 2'd2) |=> waddr_w == $past(waddr_w) + 8'd1);
    assert_phase_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 4'h0) |=> wph_w == 2'd0);
endmodule

bind clut_host_port clut_host_port_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_sel     (host_sel),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .host_rvalid  (host_rvalid),
    .pix_valid    (pix_valid),
    .pix_out_valid(pix_out_valid),
    .pix_rgb      (pix_rgb),
    .misc_w       (misc_w),
    .waddr_w      (u_regs.st_q.waddr),
    .wph_w        (wph_w)
);

// File: tb/clut_host_port_tb_top.sv
module clut_host_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  host_sel = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_rvalid;
    logic        pix_valid = 1'b0;
    logic [7:0]  pix_index = '0;
    logic        pix_out_valid;
    logic [23:0] pix_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [23:0] model [256];
    logic [7:0]  m_mask = 8'h00;
    logic [7:0]  m_misc = 8'h00;

    logic [7:0]  hq_exp [$];
    string       hq_tag [$];
    logic [23:0] pq_exp [$];
    string       pq_tag [$];

    always #2 clk = ~clk;

    clut_host_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .pix_valid(pix_valid), .pix_index(pix_index),
        .pix_out_valid(pix_out_valid), .pix_rgb(pix_rgb)
    );

    task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hwr(input logic [3:0] sel, input logic [7:0] d);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [3:0] sel, input logic [7:0] exp, input string tag);
        host_sel = sel; host_rd = 1'b1;
        hq_exp.push_back(exp); hq_tag.push_back(tag);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic put_triple(input logic [7:0] addr, input logic [23:0] rgb);
        hwr(4'h1, rgb[23:16]); hwr(4'h1, rgb[15:8]); hwr(4'h1, rgb[7:0]);
        model[addr] = rgb;
    endtask

    task automatic get_triple(input logic [23:0] rgb, input string tag);
        hrd(4'h1, rgb[23:16], tag); hrd(4'h1, rgb[15:8], tag); hrd(4'h1, rgb[7:0], tag);
    endtask

    task automatic pix(input logic [7:0] idx, input string tag);
        logic [23:0] e;
        e = model[idx & m_mask];
        if (m_misc[0]) e = 24'h0;
        else if (!m_misc[1]) e = {e[23:16] >> 2, e[15:8] >> 2, e[7:0] >> 2};
        pix_index = idx; pix_valid = 1'b1;
        pq_exp.push_back(e); pq_tag.push_back(tag);
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            if (hq_exp.size() == 0) check(1'b0, "R3 unexpected read", {16'h0, host_rdata}, 24'h0);
            else begin
                logic [7:0] e;
                string t;
                e = hq_exp.pop_front(); t = hq_tag.pop_front();
                check(host_rdata === e, t, {16'h0, host_rdata}, {16'h0, e});
            end
        end
        if (rst_n && pix_out_valid) begin
            if (pq_exp.size() == 0) check(1'b0, "R6 unexpected pixel", pix_rgb, 24'h0);
            else begin
                logic [23:0] e;
                string t;
                e = pq_exp.pop_front(); t = pq_tag.pop_front();
                check(pix_rgb === e, t, pix_rgb, e);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(host_rvalid == 1'b0, "R1 rvalid idle", {23'h0, host_rvalid}, 24'h0);
        check(pix_out_valid == 1'b0, "R1 pix idle", {23'h0, pix_out_valid}, 24'h0);
        hrd(4'h0, 8'h00, "R1 waddr reset");
        hrd(4'h2, 8'h00, "R1 mask reset");
        hrd(4'h3, 8'h00, "R1 raddr reset");
        hwr(4'h0, 8'h1E);
        hrd(4'hA, 8'h00, "R1 misc reset");

        // R7: indirect access
        hwr(4'hA, 8'h02); m_misc = 8'h02;
        hrd(4'hA, 8'h02, "R7 misc readback");
        hwr(4'h0, 8'h1C);
        hwr(4'hA, 8'h55);
        hrd(4'hA, 8'h00, "R7 other index reads zero");
        hwr(4'h0, 8'h1E);
        hrd(4'hA, 8'h02, "R7 misc unaffected");

        // R2: streamed writes
        hwr(4'h0, 8'h10);
        put_triple(8'h10, 24'h123456);
        put_triple(8'h11, 24'hA1B2C3);
        put_triple(8'h12, 24'hFFEEDD);
        hrd(4'h0, 8'h13, "R2 waddr advanced");

        // R3: streamed reads
        hwr(4'h3, 8'h10);
        get_triple(24'h123456, "R3 read 0x10");
        get_triple(24'hA1B2C3, "R3 read 0x11");
        get_triple(24'hFFEEDD, "R3 read 0x12");
        hrd(4'h3, 8'h13, "R3 raddr advanced");

        // R4: restart abandons partial triple
        hwr(4'h0, 8'h20);
        put_triple(8'h20, 24'h0F1E2D);
        hwr(4'h0, 8'h20);
        hwr(4'h1, 8'hEE); hwr(4'h1, 8'hEE);
        hwr(4'h0, 8'h20);
        hwr(4'h3, 8'h20);
        get_triple(24'h0F1E2D, "R4 partial left table intact");
        hwr(4'h0, 8'h20);
        put_triple(8'h20, 24'h778899);
        hwr(4'h3, 8'h20);
        get_triple(24'h778899, "R4 fresh triple after restart");
        hwr(4'h3, 8'h10);
        hrd(4'h1, 8'h12, "R4 read phase");
        hwr(4'h3, 8'h11);
        get_triple(24'hA1B2C3, "R4 read restart at red");

        // R5: coherence of captured entry
        hwr(4'h3, 8'h11);
        hrd(4'h1, 8'hA1, "R5 red");
        hwr(4'h0, 8'h11);
        put_triple(8'h11, 24'h010203);
        hrd(4'h1, 8'hB2, "R5 green from captured entry");
        hrd(4'h1, 8'hC3, "R5 blue from captured entry");
        hwr(4'h3, 8'h11);
        get_triple(24'h010203, "R5 new entry later");

        // R10: wrap
        hwr(4'h0, 8'hFF);
        put_triple(8'hFF, 24'hCAFE01);
        put_triple(8'h00, 24'hBEEF02);
        hrd(4'h0, 8'h01, "R10 waddr wrapped");
        hwr(4'h3, 8'hFF);
        get_triple(24'hCAFE01, "R10 read 0xFF");
        get_triple(24'hBEEF02, "R10 read wrapped 0x00");
        hrd(4'h3, 8'h01, "R10 raddr wrapped");

        // R6: masked pixel lookup, 8-bit mode
        hwr(4'h2, 8'hFF); m_mask = 8'hFF;
        hrd(4'h2, 8'hFF, "R6 mask readback");
        pix(8'h10, "R6 lookup 0x10");
        pix(8'h12, "R6 lookup 0x12");
        pix(8'h20, "R6 back-to-back");
        hwr(4'h2, 8'h1F); m_mask = 8'h1F;
        pix(8'h30, "R6 masked 0x30 to 0x10");
        pix(8'hF2, "R6 masked 0xF2 to 0x12");
        pix(8'h00, "R6 lookup 0x00");

        // R8: 6-bit mode
        hwr(4'h0, 8'h1E);
        hwr(4'hA, 8'h00); m_misc = 8'h00;
        pix(8'h12, "R8 narrow 0x12");
        pix(8'h20, "R8 narrow 0x20");

        // R9: DAC off
        hwr(4'hA, 8'h03); m_misc = 8'h03;
        pix(8'h12, "R9 off yields zero");
        hwr(4'hA, 8'h01); m_misc = 8'h01;
        pix(8'h10, "R9 off in 6-bit mode");
        hwr(4'hA, 8'h02); m_misc = 8'h02;
        pix(8'h11, "R9 on again");

        repeat (4) @(negedge clk);
        check(hq_exp.size() == 0, "R3 all reads answered", hq_exp.size(), 24'h0);
        check(pq_exp.size() == 0, "R6 all pixels answered", pq_exp.size(), 24'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule